// File: doc/BRIEF.md
# Synchronous FIFO with Status Flags

A single-clock first-in first-out buffer of 16 entries, each 8 bits wide. A producer pushes a byte by raising the write enable with data on the input bus; a consumer pops a byte by raising the read enable and finds the byte on the output bus one clock later. Storage is a register array addressed by two wrapping 4-bit pointers, and a 5-bit occupancy count drives the status outputs.

Besides full and empty, the block reports misuse. A push that cannot be taken, or a pop from an empty buffer, produces a one-cycle error pulse and leaves the contents untouched. A low-water indicator compares the occupancy with a level supplied on an input every cycle, so a producer can be told to refill before the buffer runs dry.

Top module: `fifo_flagged`

## Requirements
- R1: While `rst` is high at a rising edge, the buffer is emptied: after that edge `empty`=1, `full`=0, `overflow`=0, `underflow`=0 and `rd_data`=0.
- R2: Bytes leave in the order they were accepted; a pop accepted at an edge (`rd_en`=1 and `empty`=0) presents the oldest byte on `rd_data` after that edge, and `rd_data` holds its value in every cycle without an accepted pop.
- R3: `full` is 1 exactly when 16 entries are stored.
- R4: `empty` is 1 exactly when no entry is stored.
- R5: A push with `wr_en`=1 and `rd_en`=0 while `full`=1 is discarded, and `overflow` is 1 for exactly the following cycle; `overflow` is 0 in every other cycle.
- R6: A pop with `rd_en`=1 while `empty`=1 is ignored (no pointer moves, `rd_data` unchanged), and `underflow` is 1 for exactly the following cycle; `underflow` is 0 in every other cycle. A push in the same cycle is still accepted.
- R7: A push and a pop in the same cycle with `empty`=0 are both accepted and leave the occupancy unchanged, also when `full`=1.
- R8: `below_mark` is 1 exactly when the stored-entry count, as an unsigned 5-bit number, is less than `level_mark`, taken in the same cycle.
- R9: Both pointers wrap from the last slot to the first, so FIFO order holds across any number of passes through the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push request |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 8 | Byte popped, registered |
| level_mark | input | 5 | Low-water level for `below_mark` |
| full | output | 1 | 16 entries stored |
| empty | output | 1 | No entry stored |
| overflow | output | 1 | Pulse after a discarded push |
| underflow | output | 1 | Pulse after a pop from empty |
| below_mark | output | 1 | Occupancy below `level_mark` |

## Verification
The hardest states to reach are the edges of occupancy combined with simultaneous traffic: a push and a pop arriving together while the buffer is full, and a push arriving with a pop while it is empty. Balanced random traffic rarely reaches 16 entries, so the stimulus runs in phases that bias the push and pop probabilities strongly one way and then the other. These phases drive the buffer to the full and empty limits many times, where random collisions and misuse happen. Directed sequences also fill the buffer exactly, and then issue a lone push, a paired push and pop, and a pop from empty.

// File: rtl/fifo_flagged.sv
module fifo_flagged #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [CW-1:0]    level_mark,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             underflow,
  output logic             below_mark
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             push, pop;

  assign full       = (count == CW'(DEPTH));
  assign empty      = (count == '0);
  assign below_mark = (count < level_mark);

  assign pop  = rd_en && !empty;
  assign push = wr_en && (!full || rd_en);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      rd_data   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= wr_en && !push;
      underflow <= rd_en && empty;
      if (push) wptr <= wptr + 1'b1;
      if (pop) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

module fifo_flagged_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic             full,
  input logic             empty,
  input logic             overflow,
  input logic             underflow
);

  // R3
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R5
  overflow_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && full) |=> (overflow && full));

  // R5
  overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($past(wr_en) && !$past(rd_en) && $past(full)));

  // R6
  underflow_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && empty) |=> (underflow && empty));

  // R6
  underflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |-> ($past(rd_en) && $past(empty)));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !empty) |=> $stable(rd_data));

  // R7
  pair_level_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !empty) |=> ($stable(full) && $stable(empty)));

endmodule

bind fifo_flagged fifo_flagged_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .full(full), .empty(empty), .overflow(overflow), .underflow(underflow)
);

// File: tb/fifo_flagged_tb.sv
module fifo_flagged_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [4:0] level_mark = 5'd4;
  logic       full, empty, overflow, underflow, below_mark;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] mq[$];
  logic [7:0] exp_rd = '0;
  logic       exp_ovf = 1'b0, exp_unf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_flagged u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .level_mark(level_mark), .full(full), .empty(empty),
    .overflow(overflow), .underflow(underflow), .below_mark(below_mark)
  );

  function automatic logic f_below(int n, logic [4:0] m);
    return n < int'(m);
  endfunction

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "full R3", 8'(full), 8'(mq.size() == DEPTH));
    chk(tag, "empty R4", 8'(empty), 8'(mq.size() == 0));
    chk(tag, "overflow R5", 8'(overflow), 8'(exp_ovf));
    chk(tag, "underflow R6", 8'(underflow), 8'(exp_unf));
    chk(tag, "below_mark R8", 8'(below_mark), 8'(f_below(mq.size(), level_mark)));
    chk(tag, "rd_data R2", rd_data, exp_rd);
  endtask

  task automatic step(logic w, logic r, logic [7:0] d, logic [4:0] m, string tag);
    int n;
    logic acc_w, acc_r;
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d; level_mark = m;
    n = mq.size();
    acc_r = r && (n > 0);
    acc_w = w && ((n < DEPTH) || r);
    exp_ovf = w && !acc_w;
    exp_unf = r && (n == 0);
    @(posedge clk);
    #1;
    if (acc_r) exp_rd = mq.pop_front();
    if (acc_w) mq.push_back(d);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check_all("R1 reset");
    @(negedge clk);
    rst = 1'b0;

    step(1'b0, 1'b1, 8'h00, 5'd1, "R6 pop from empty");
    step(1'b1, 1'b1, 8'hA5, 5'd1, "R6 push with pop from empty");
    step(1'b0, 1'b1, 8'h00, 5'd1, "R2 single pop");
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 1'b0, 8'(8'h10 + i), 5'(i), "R3 fill");
    step(1'b1, 1'b0, 8'hEE, 5'd16, "R5 push while full");
    step(1'b0, 1'b0, 8'h00, 5'd16, "R5 pulse ends");
    step(1'b1, 1'b1, 8'h77, 5'd17, "R7 push and pop while full");
    step(1'b1, 1'b1, 8'h78, 5'd31, "R7 pair again");
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, 1'b1, 8'h00, 5'(i), "R9 drain across wrap");
    step(1'b0, 1'b1, 8'h00, 5'd0, "R6 pop after drain");
    step(1'b0, 1'b0, 8'h00, 5'd0, "R8 mark zero");

    rst = 1'b1;
    @(posedge clk);
    #1;
    mq.delete(); exp_rd = '0; exp_ovf = 1'b0; exp_unf = 1'b0;
    check_all("R1 mid-run reset");
    @(negedge clk);
    rst = 1'b0;

    for (int ph = 0; ph < 40; ph++) begin
      int pw = (ph % 2 == 0) ? 85 : 20;
      int pr = (ph % 2 == 0) ? 20 : 85;
      if (ph % 5 == 4) begin pw = 50; pr = 50; end
      for (int k = 0; k < 60; k++)
        step(($urandom % 100) < pw, ($urandom % 100) < pr,
             8'($urandom), 5'($urandom % 18), "R9 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule